// File: doc/BRIEF.md
# Bidirectional I/O Port with Peripheral Pin Takeover

This block is an 8-bit general-purpose I/O port on a simple register bus. Two registers control it. An output latch holds the value that is driven onto output pins. A direction register turns each pin's output buffer on or off. Every pin level is passed through a two-stage synchronizer before any logic uses it.

Four pins can be claimed by on-chip peripherals:

- A serial unit takes pin 0 as its transmit output and pin 1 as its receive input while its enable is high.
- Two timer capture/compare channels each claim one pin: channel 0 uses pin 2 and channel 1 uses pin 3. A channel claims its pin while its 2-bit mode field is nonzero.

While a peripheral owns a pin, the peripheral sets that pin's drive value and buffer enable. Register reads ignore ownership: the direction bit alone decides whether a bit of the data read comes from the latch or from the synchronized pin. Software can therefore always see either its own latch contents or the real pin level.

Top module: `gpio_port_ovr`

## Requirements
- R1: After a synchronous active-low reset, the latch and the direction register are 0x00 and every pin_oe bit is 0.
- R2: For a pin that no peripheral owns, pin_oe equals its direction bit (1 = output) and pin_out equals its latch bit.
- R3: A read at address 0x08 returns, for each bit, the latch bit when the direction bit is 1, and the pin level when it is 0. The pin level is delayed by two clock edges through the synchronizer.
- R4: A write to the latch at 0x08 takes effect while the pin is an input. After the direction bit is then set, pin_out already shows the preloaded value in the first cycle pin_oe is 1.
- R5: While sci_en is 1, pin 0 has pin_oe=1 and pin_out=sci_tx, and pin 1 has pin_oe=0, whatever their direction bits are. Clearing sci_en returns both pins to R2 behaviour.
- R6: sci_rx is the level of pin 1 after the two-stage synchronizer.
- R7: While the mode field of timer channel k (tmr_mode[2k+1:2k]) is nonzero, pin 2+k takes pin_oe from tmr_oe[k] and pin_out from tmr_drive[k]. A zero field returns the pin to R2 behaviour.
- R8: The R3 read rule also applies to pins that a peripheral owns.
- R9: A write to any address other than 0x08 and 0x0C changes neither register. A read of such an address returns 0x00.
- R10: The direction register at address 0x0C can be written and read back as all 8 bits.
- R11: tmr_cap[k] is the level of pin 2+k after the two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Value driven on each pin |
| pin_oe | output | 8 | Output buffer enable for each pin |
| sci_en | input | 1 | Serial unit claims pins 0 and 1 |
| sci_tx | input | 1 | Serial transmit level |
| sci_rx | output | 1 | Synchronized receive level from pin 1 |
| tmr_mode | input | 4 | Mode field of each timer channel, 2 bits each |
| tmr_oe | input | 2 | Timer output enable for each channel |
| tmr_drive | input | 2 | Timer drive level for each channel |
| tmr_cap | output | 2 | Synchronized levels of pins 2 and 3 |

## Verification
The read path is tried with these patterns:

- Mixed direction masks with latch and pin values that differ in every bit, so a bit taken from the wrong source shows up.
- A pin change sampled after one clock edge and again after two, which separates correct synchronizer latency from a stage too few or too many.

Ownership is tried by setting the direction register so that it contradicts what the serial unit or the timer asks for. An output that followed the register instead of the peripheral then shows a visible difference. The same pattern is repeated after ownership is released. Reads from owned pins cover both direction settings. Undecoded-address writes use a pattern that neither register already holds.

// File: rtl/gpio_ovr_pkg.sv
// Package: shared constants for the peripheral-override I/O port.
// Assumes a byte-wide register bus with byte addresses.
package gpio_ovr_pkg;
    localparam int PORT_W    = 8;
    localparam int ADDR_W    = 8;
    localparam int TX_PIN    = 0;
    localparam int RX_PIN    = 1;
    localparam int TMR_BASE  = 2;
    localparam int N_TMR     = 2;
    localparam int MODE_W    = 2;
    localparam logic [ADDR_W-1:0] LATCH_ADDR = 8'h08;
    localparam logic [ADDR_W-1:0] DIR_ADDR   = 8'h0C;
endpackage

// File: rtl/gpio_in_sync.sv
// Module: two-flop synchronizer, one lane per pin.
// Assumes the lanes are independent single-bit levels. Reset clears both stages.
module gpio_in_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Shift each pin level through two flop stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_async;
            stage2_q <= stage1_q;
        end
    end

    assign d_sync = stage2_q;

    // R3 R6 R11
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (d_sync == $past(d_async, 2)));
endmodule

// File: rtl/gpio_regs.sv
// Module: output latch and direction register, with address decode and read mux.
// Assumes single-cycle writes and a combinational read of the addressed register.
module gpio_regs
    import gpio_ovr_pkg::*;
#(
    parameter int W  = PORT_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [W-1:0]  bus_wdata,
    input  logic [W-1:0]  pins_sync,
    output logic [W-1:0]  bus_rdata,
    output logic [W-1:0]  latch_q,
    output logic [W-1:0]  dir_q
);
    logic hit_latch;
    logic hit_dir;

    assign hit_latch = (bus_addr == AW'(LATCH_ADDR));
    assign hit_dir   = (bus_addr == AW'(DIR_ADDR));

    // Latch register: written whatever the pin direction is.
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= '0;
        else if (bus_we && hit_latch)
            latch_q <= bus_wdata;
    end

    // Direction register: 1 enables the output buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_q <= '0;
        else if (bus_we && hit_dir)
            dir_q <= bus_wdata;
    end

    // Read mux: each direction bit picks latch or pin; undecoded addresses read zero.
    always_comb begin
        if (hit_latch)
            bus_rdata = (dir_q & latch_q) | (~dir_q & pins_sync);
        else if (hit_dir)
            bus_rdata = dir_q;
        else
            bus_rdata = '0;
    end

    // R4
    latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit_latch) |=> (latch_q == $past(bus_wdata)));
    // R10
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit_dir) |=> (dir_q == $past(bus_wdata)));
    // R9
    undecoded_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !hit_latch && !hit_dir) |=> ($stable(latch_q) && $stable(dir_q)));
endmodule

// File: rtl/gpio_pin_mux.sv
// Module: chooses, for each pin, between register control and peripheral control.
// Assumes fixed pin positions for serial transmit/receive and for the timer channels.
module gpio_pin_mux
    import gpio_ovr_pkg::*;
#(
    parameter int W   = PORT_W,
    parameter int NT  = N_TMR,
    parameter int MW  = MODE_W,
    parameter int TXP = TX_PIN,
    parameter int RXP = RX_PIN,
    parameter int TB  = TMR_BASE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  latch_q,
    input  logic [W-1:0]  dir_q,
    input  logic          sci_en,
    input  logic          sci_tx,
    input  logic [NT*MW-1:0] tmr_mode,
    input  logic [NT-1:0] tmr_oe,
    input  logic [NT-1:0] tmr_drive,
    output logic [W-1:0]  pin_out,
    output logic [W-1:0]  pin_oe
);
    logic [W-1:0] owned;

    for (genvar i = 0; i < W; i++) begin : g_pin
        if (i == TXP) begin : g_tx
            // Transmit pin: the serial unit drives it while enabled.
            assign owned[i]   = sci_en;
            assign pin_out[i] = sci_en ? sci_tx : latch_q[i];
            assign pin_oe[i]  = sci_en | dir_q[i];
        end else if (i == RXP) begin : g_rx
            // Receive pin: forced to input while the serial unit is enabled.
            assign owned[i]   = sci_en;
            assign pin_out[i] = latch_q[i];
            assign pin_oe[i]  = ~sci_en & dir_q[i];
        end else if (i >= TB && i < TB + NT) begin : g_tmr
            // Timer pin: owned while the channel's mode field is nonzero.
            localparam int K = i - TB;
            assign owned[i]   = |tmr_mode[K*MW +: MW];
            assign pin_out[i] = owned[i] ? tmr_drive[K] : latch_q[i];
            assign pin_oe[i]  = owned[i] ? tmr_oe[K]    : dir_q[i];
        end else begin : g_gp
            // Plain pin: register control only.
            assign owned[i]   = 1'b0;
            assign pin_out[i] = latch_q[i];
            assign pin_oe[i]  = dir_q[i];
        end
    end

    // R2
    free_pins_follow_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owned == '0) |-> (pin_oe == dir_q && pin_out == latch_q));
    // R5
    sci_dir_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sci_en |-> (pin_oe[TXP] && !pin_oe[RXP] && pin_out[TXP] == sci_tx));
    // R7
    tmr0_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_mode[MW-1:0] != '0) |-> (pin_oe[TB] == tmr_oe[0] && pin_out[TB] == tmr_drive[0]));
endmodule

// File: rtl/gpio_port_ovr.sv
// Module: top of the 8-bit I/O port with peripheral pin takeover.
// Assumes the peripheral control inputs are synchronous to clk; only pin_in is asynchronous.
module gpio_port_ovr
    import gpio_ovr_pkg::*;
#(
    parameter int W  = PORT_W,
    parameter int AW = ADDR_W,
    parameter int NT = N_TMR,
    parameter int MW = MODE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_we,
    input  logic [W-1:0]     bus_wdata,
    output logic [W-1:0]     bus_rdata,
    input  logic [W-1:0]     pin_in,
    output logic [W-1:0]     pin_out,
    output logic [W-1:0]     pin_oe,
    input  logic             sci_en,
    input  logic             sci_tx,
    output logic             sci_rx,
    input  logic [NT*MW-1:0] tmr_mode,
    input  logic [NT-1:0]    tmr_oe,
    input  logic [NT-1:0]    tmr_drive,
    output logic [NT-1:0]    tmr_cap
);
    logic [W-1:0] pins_sync;
    logic [W-1:0] latch_q;
    logic [W-1:0] dir_q;

    gpio_in_sync #(.W(W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .d_sync  (pins_sync)
    );

    gpio_regs #(.W(W), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .pins_sync (pins_sync),
        .bus_rdata (bus_rdata),
        .latch_q   (latch_q),
        .dir_q     (dir_q)
    );

    gpio_pin_mux #(.W(W), .NT(NT), .MW(MW)) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch_q   (latch_q),
        .dir_q     (dir_q),
        .sci_en    (sci_en),
        .sci_tx    (sci_tx),
        .tmr_mode  (tmr_mode),
        .tmr_oe    (tmr_oe),
        .tmr_drive (tmr_drive),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    assign sci_rx  = pins_sync[RX_PIN];
    assign tmr_cap = pins_sync[TMR_BASE +: NT];
endmodule

// File: tb/sim_gpio_port_ovr.sv
module sim_gpio_port_ovr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic       sci_en = 1'b0;
    logic       sci_tx = 1'b0;
    logic       sci_rx;
    logic [3:0] tmr_mode = 4'h0;
    logic [1:0] tmr_oe = 2'b00;
    logic [1:0] tmr_drive = 2'b00;
    logic [1:0] tmr_cap;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_port_ovr u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .sci_en(sci_en), .sci_tx(sci_tx),
        .sci_rx(sci_rx), .tmr_mode(tmr_mode), .tmr_oe(tmr_oe),
        .tmr_drive(tmr_drive), .tmr_cap(tmr_cap)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_pins(input logic [7:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(8'h08, d); check("R1 latch/read", d, 8'h00);
        rd(8'h0C, d); check("R1 dir", d, 8'h00);
        check("R1 oe", pin_oe, 8'h00);
    endtask

    task automatic t_dir_rw();
        logic [7:0] d;
        wr(8'h0C, 8'h5A); rd(8'h0C, d); check("R10 dir 5A", d, 8'h5A);
        wr(8'h0C, 8'hA5); rd(8'h0C, d); check("R10 dir A5", d, 8'hA5);
        wr(8'h0C, 8'h00);
    endtask

    task automatic t_gp_out();
        wr(8'h08, 8'h3C);
        wr(8'h0C, 8'hF0);
        check("R2 oe", pin_oe, 8'hF0);
        check("R2 out", pin_out, 8'h3C);
        wr(8'h0C, 8'h00);
        check("R2 oe off", pin_oe, 8'h00);
    endtask

    task automatic t_read_src();
        logic [7:0] d;
        wr(8'h08, 8'hFF);
        wr(8'h0C, 8'h00);
        @(negedge clk); pin_in = 8'hA5;
        @(negedge clk); rd(8'h08, d); check("R3 one edge old", d, 8'h00);
        @(negedge clk); rd(8'h08, d); check("R3 two edges new", d, 8'hA5);
        wr(8'h08, 8'h0F);
        wr(8'h0C, 8'hF0);
        set_pins(8'h3C);
        rd(8'h08, d); check("R3 mixed", d, 8'h0C);
        wr(8'h0C, 8'h00);
    endtask

    task automatic t_preload();
        wr(8'h0C, 8'h00);
        wr(8'h08, 8'h81);
        check("R4 still input", pin_oe, 8'h00);
        @(negedge clk);
        bus_addr = 8'h0C; bus_wdata = 8'hFF; bus_we = 1'b1;
        @(posedge clk); #1;
        check("R4 oe rises", pin_oe, 8'hFF);
        check("R4 no glitch", pin_out, 8'h81);
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic t_sci();
        wr(8'h08, 8'hFF);
        wr(8'h0C, 8'hFE);
        @(negedge clk); sci_en = 1'b1; sci_tx = 1'b0;
        #1;
        check("R5 oe", pin_oe[1:0], 8'h01);
        check("R5 tx low", pin_out[0], 8'h00);
        sci_tx = 1'b1; #1;
        check("R5 tx high", pin_out[0], 8'h01);
        set_pins(8'h02);
        check("R6 rx high", sci_rx, 8'h01);
        set_pins(8'h00);
        check("R6 rx low", sci_rx, 8'h00);
        @(negedge clk); sci_en = 1'b0; #1;
        check("R5 release", pin_oe[1:0], 8'h02);
        wr(8'h0C, 8'h00);
    endtask

    task automatic t_timer();
        logic [7:0] d;
        wr(8'h08, 8'h00);
        wr(8'h0C, 8'h08);
        @(negedge clk); tmr_mode = 4'b0001; tmr_oe = 2'b01; tmr_drive = 2'b01; #1;
        check("R7 ch0 oe", pin_oe[3:2], 8'h03);
        check("R7 ch0 out", pin_out[2], 8'h01);
        @(negedge clk); tmr_mode = 4'b1101; tmr_oe = 2'b01; #1;
        check("R7 ch1 oe", pin_oe[3:2], 8'h01);
        @(negedge clk); tmr_mode = 4'b0000; #1;
        check("R7 release", pin_oe[3:2], 8'h02);
        @(negedge clk); tmr_mode = 4'b0010;
        wr(8'h0C, 8'h04);
        set_pins(8'h0C);
        rd(8'h08, d); check("R8 owned dir1 latch", d[3:2], 8'h02);
        check("R11 cap", tmr_cap, 8'h03);
        wr(8'h0C, 8'h00);
        rd(8'h08, d); check("R8 owned dir0 pin", d[3:2], 8'h03);
        set_pins(8'h04);
        check("R11 cap ch0", tmr_cap, 8'h01);
        @(negedge clk); tmr_mode = 4'b0000;
    endtask

    task automatic t_undecoded();
        logic [7:0] d;
        wr(8'h08, 8'h11);
        wr(8'h0C, 8'h22);
        wr(8'h09, 8'hEE);
        wr(8'h00, 8'hEE);
        rd(8'h0C, d); check("R9 dir kept", d, 8'h22);
        check("R9 latch kept", pin_out & 8'h22, 8'h00);
        wr(8'h0C, 8'hFF);
        check("R9 latch kept out", pin_out, 8'h11);
        rd(8'h09, d); check("R9 read zero", d, 8'h00);
        wr(8'h0C, 8'h00);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dir_rw();
        t_gp_out();
        t_read_src();
        t_preload();
        t_sci();
        t_timer();
        t_undecoded();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule